// File: doc/BRIEF.md
# Event Steering Unit

The unit gathers a vector of event lines (99 by default: pad-level signals and on-chip signals alike) and turns each one into a conditioned request. Every line has its own choice of level or edge sensitivity and its own polarity. A conditioned request first passes a per-line global enable. It then passes a separate enable for each of the five outputs. Each output is the OR of the requests that reach it. Outputs 0 to 3 are interrupt requests. Output 4 is a wakeup request, and its consumer acts on the rising edge.

Event lines are treated as asynchronous and pass through a two-flop synchroniser. An edge-mode event is caught in a sticky bit that software clears by writing one to the raw status location. Software reaches all configuration and status through a single-cycle register port. A word address is split as bank = addr[7:2] and group = addr[1:0]. Group g covers events 32g to 32g+31, with event 32g+b at bit b. The banks are: 0 mode (1 = edge, 0 = level), 1 polarity (0 = active-high or rising, 1 = active-low or falling), 2 global enable, 3 raw status (write one to clear), 4 pending, 5–9 per-output enable for outputs 0–4, 10–14 per-output pending for outputs 0–4, and 15 output state (group 0 only, bit k = output k). Read data is combinational while `bus_sel` is high and `bus_wr` is low.

Top module: `evt_steer`

## Requirements
- R1: After reset, every mode, polarity, global enable and per-output enable bit reads 0, and all outputs are low.
- R2: In level mode a raw status bit equals the synchronised input when polarity is 0, or its inverse when polarity is 1. It is valid two clock edges after the input changes.
- R3: In edge mode a raw status bit is set by a rising edge when polarity is 0, or by a falling edge when polarity is 1. An edge of the other direction does not set it. Once set, it stays set after the input returns, until cleared.
- R4: Writing bank 3 clears the edge-mode raw bits where the write data holds a one. Zero data bits, and bits of level-mode events, are not affected.
- R5: A pending bit (bank 4) is the raw bit ANDed with the global enable bit of that event.
- R6: A per-output pending bit (banks 10–14) is the pending bit ANDed with that output's enable bit for the event.
- R7: Output k (irq_out[k] for k < 4, wake_out for k = 4) is the OR of its per-output pending bits. Bank 15 reads the five outputs at bits 4:0.
- R8: Bits of group 3 above event 98 (bits 31:3) read as zero in every bank, and writes to them are ignored.
- R9: The mode, polarity, global enable and per-output enable banks read back the value last written within valid bits, and hold it while no write targets them.
- R10: Addresses with no bank (bank 16 and above), and groups 1 to 3 of bank 15, read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_in | input | 99 | Asynchronous event lines |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Word address: bank in 7:2, group in 1:0 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not reading |
| irq_out | output | 4 | Interrupt requests, outputs 0–3 |
| wake_out | output | 1 | Wakeup request, output 4 |

## Verification
A corrupted edge latch shows at the ports as a raw status bit that drops without a clear, or one that survives a one-to-clear write. Either is visible on the next read of bank 3, and also on the routed output in the same cycle. A wrong enable bit shows at once as an output asserted for an event that was never routed to it, or one missing for an event that was. A synchroniser or previous-sample fault moves the raw bit by one or more cycles, or loses an edge altogether. The bench therefore checks each line's status and every output after a fixed settle time, across both sensitivities and both polarities.

// File: rtl/evt_pkg.sv
package evt_pkg;
    parameter int unsigned DW = 32;

    // bank numbers of the register port
    localparam int unsigned BK_MODE = 0;
    localparam int unsigned BK_POL  = 1;
    localparam int unsigned BK_GEN  = 2;
    localparam int unsigned BK_RAW  = 3;
    localparam int unsigned BK_PEND = 4;
    localparam int unsigned BK_OEN  = 5;

    function automatic int unsigned grp_count(int unsigned n);
        return (n + DW - 1) / DW;
    endfunction
endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
    parameter int unsigned N      = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [STAGES-1:0][N-1:0] st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                st_q[i] <= st_q[i-1];
            end
        end
    end

    assign q = st_q[STAGES-1];
endmodule

// File: rtl/evt_detect.sv
module evt_detect #(
    parameter int unsigned N = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    input  logic [N-1:0] mode,
    input  logic [N-1:0] pol,
    input  logic [N-1:0] clr,
    output logic [N-1:0] raw
);
    logic [N-1:0] prev_q;
    logic [N-1:0] latch_q;
    logic [N-1:0] hit;

    always_comb hit = (din & ~prev_q & ~pol) | (~din & prev_q & pol);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '0;
            latch_q <= '0;
        end else begin
            prev_q  <= din;
            latch_q <= mode & ((latch_q & ~clr) | hit);
        end
    end

    assign raw = (mode & latch_q) | (~mode & (din ^ pol));

    AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (rst)
        ((mode & $past(mode) & $past(raw) & ~$past(clr) & ~raw) == '0)); // R3
    AST_LEVEL_NO_LATCH: assert property (@(posedge clk) disable iff (rst)
        ((~$past(mode) & latch_q) == '0)); // R4
endmodule

// File: rtl/evt_route.sv
module evt_route #(
    parameter int unsigned N     = 1,
    parameter int unsigned N_OUT = 1
) (
    input  logic [N-1:0]            pend,
    input  logic [N_OUT-1:0][N-1:0] oen,
    output logic [N_OUT-1:0][N-1:0] opnd,
    output logic [N_OUT-1:0]        out
);
    for (genvar k = 0; k < N_OUT; k++) begin : g_out
        assign opnd[k] = pend & oen[k];
        assign out[k]  = |opnd[k];
    end
endmodule

// File: rtl/evt_steer.sv
module evt_steer
    import evt_pkg::*;
#(
    parameter int unsigned N_EVT  = 99,
    parameter int unsigned N_OUT  = 5,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_EVT-1:0]  ev_in,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic [N_OUT-2:0]  irq_out,
    output logic              wake_out
);
    localparam int unsigned NGRP    = grp_count(N_EVT);
    localparam int unsigned GRP_W   = (NGRP > 1) ? $clog2(NGRP) : 1;
    localparam int unsigned PADW    = (1 << GRP_W) * DW;
    localparam int unsigned BK_OPND = BK_OEN + N_OUT;
    localparam int unsigned BK_OUT  = BK_OPND + N_OUT;
    localparam logic [PADW-1:0] VALID = {PADW{1'b1}} >> (PADW - N_EVT);
    localparam logic [DW-1:0] TOP_MASK = VALID[(NGRP-1)*DW +: DW];

    logic [PADW-1:0]             mode_q, pol_q, gen_q;
    logic [N_OUT-1:0][PADW-1:0]  oen_q;
    logic [PADW-1:0]             clr_pad, raw_pad, pend_pad;
    logic [N_OUT-1:0][PADW-1:0]  opnd_pad;
    logic [N_EVT-1:0]            ev_sync, raw, pend;
    logic [N_OUT-1:0][N_EVT-1:0] oen_v, opnd_v;
    logic [N_OUT-1:0]            out_v;
    int unsigned                 bank_i, grp_i;
    logic                        wr_go, rd_go;

    always_comb begin
        bank_i = 32'(bus_addr[ADDR_W-1:GRP_W]);
        grp_i  = 32'(bus_addr[GRP_W-1:0]);
    end
    assign wr_go = bus_sel && bus_wr;
    assign rd_go = bus_sel && !bus_wr;

    // configuration banks
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            pol_q  <= '0;
            gen_q  <= '0;
            oen_q  <= '0;
        end else if (wr_go) begin
            if (bank_i == BK_MODE) mode_q[grp_i*DW +: DW] <= bus_wdata & VALID[grp_i*DW +: DW];
            if (bank_i == BK_POL)  pol_q[grp_i*DW +: DW]  <= bus_wdata & VALID[grp_i*DW +: DW];
            if (bank_i == BK_GEN)  gen_q[grp_i*DW +: DW]  <= bus_wdata & VALID[grp_i*DW +: DW];
            for (int k = 0; k < N_OUT; k++) begin
                if (bank_i == BK_OEN + k)
                    oen_q[k][grp_i*DW +: DW] <= bus_wdata & VALID[grp_i*DW +: DW];
            end
        end
    end

    always_comb begin
        clr_pad = '0;
        if (wr_go && bank_i == BK_RAW) clr_pad[grp_i*DW +: DW] = bus_wdata;
    end

    evt_sync #(.N(N_EVT), .STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .d(ev_in), .q(ev_sync)
    );

    evt_detect #(.N(N_EVT)) u_det (
        .clk(clk), .rst(rst), .din(ev_sync),
        .mode(mode_q[N_EVT-1:0]), .pol(pol_q[N_EVT-1:0]),
        .clr(clr_pad[N_EVT-1:0]), .raw(raw)
    );

    assign pend = raw & gen_q[N_EVT-1:0];

    for (genvar k = 0; k < N_OUT; k++) begin : g_oen
        assign oen_v[k] = oen_q[k][N_EVT-1:0];
        always_comb begin
            opnd_pad[k] = '0;
            opnd_pad[k][N_EVT-1:0] = opnd_v[k];
        end
        AST_OUT_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
            out_v[k] |-> |(oen_q[k][N_EVT-1:0] & gen_q[N_EVT-1:0] & raw)); // R6
    end

    evt_route #(.N(N_EVT), .N_OUT(N_OUT)) u_route (
        .pend(pend), .oen(oen_v), .opnd(opnd_v), .out(out_v)
    );

    always_comb begin
        raw_pad  = '0;
        pend_pad = '0;
        raw_pad[N_EVT-1:0]  = raw;
        pend_pad[N_EVT-1:0] = pend;
    end

    // read port
    always_comb begin
        bus_rdata = '0;
        if (rd_go) begin
            if (bank_i == BK_MODE) bus_rdata = mode_q[grp_i*DW +: DW];
            if (bank_i == BK_POL)  bus_rdata = pol_q[grp_i*DW +: DW];
            if (bank_i == BK_GEN)  bus_rdata = gen_q[grp_i*DW +: DW];
            if (bank_i == BK_RAW)  bus_rdata = raw_pad[grp_i*DW +: DW];
            if (bank_i == BK_PEND) bus_rdata = pend_pad[grp_i*DW +: DW];
            for (int k = 0; k < N_OUT; k++) begin
                if (bank_i == BK_OEN + k)  bus_rdata = oen_q[k][grp_i*DW +: DW];
                if (bank_i == BK_OPND + k) bus_rdata = opnd_pad[k][grp_i*DW +: DW];
            end
            if (bank_i == BK_OUT && grp_i == 0) bus_rdata = DW'(out_v);
        end
    end

    assign irq_out  = out_v[N_OUT-2:0];
    assign wake_out = out_v[N_OUT-1];

    AST_OUT_HAS_PEND: assert property (@(posedge clk) disable iff (rst)
        (|out_v) |-> (|pend)); // R7
    AST_TOP_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_go && grp_i == NGRP - 1 && bank_i < BK_OUT) |-> ((bus_rdata & ~TOP_MASK) == '0)); // R8
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_go |=> ($stable(mode_q) && $stable(pol_q) && $stable(gen_q) && $stable(oen_q))); // R9
endmodule

// File: tb/sim_evt_steer.sv
module sim_evt_steer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [98:0] ev_in = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq_out;
    logic        wake_out;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    evt_steer u0 (
        .clk(clk), .rst(rst), .ev_in(ev_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out), .wake_out(wake_out)
    );

    function automatic logic [7:0] ad(int bank, int grp);
        return 8'(bank * 4 + grp);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        ev_in = '0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        settle();
        rd(ad(0, 0), d); chk("R1 mode g0", d, 0);
        rd(ad(1, 1), d); chk("R1 pol g1", d, 0);
        rd(ad(2, 2), d); chk("R1 gen g2", d, 0);
        rd(ad(5, 0), d); chk("R1 oen0 g0", d, 0);
        rd(ad(3, 0), d); chk("R1 raw g0", d, 0);
        chk("R1 outputs", {27'd0, wake_out, irq_out}, 0);
    endtask

    task automatic t_level();
        logic [31:0] d;
        do_reset();
        @(negedge clk); ev_in[5] = 1'b1;
        settle();
        rd(ad(3, 0), d); chk("R2 raw level high", d, 32'h20);
        rd(ad(4, 0), d); chk("R5 pend gated", d, 0);
        wr(ad(2, 0), 32'h20);
        rd(ad(4, 0), d); chk("R5 pend enabled", d, 32'h20);
        chk("R6 no output enable", {28'd0, irq_out}, 0);
        wr(ad(7, 0), 32'h20);
        #1 chk("R7 irq2", {27'd0, wake_out, irq_out}, 32'h4);
        rd(ad(12, 0), d); chk("R6 opnd2", d, 32'h20);
        rd(ad(11, 0), d); chk("R6 opnd1 empty", d, 0);
        rd(ad(15, 0), d); chk("R7 out reg", d, 32'h4);
        @(negedge clk); ev_in[70] = 1'b1;
        wr(ad(2, 2), 32'h40);
        wr(ad(5, 2), 32'h40);
        settle();
        chk("R7 two outputs", {28'd0, irq_out}, 32'h5);
        @(negedge clk); ev_in[5] = 1'b0;
        settle();
        chk("R7 level drop", {28'd0, irq_out}, 32'h1);
    endtask

    task automatic t_polarity();
        logic [31:0] d;
        do_reset();
        wr(ad(1, 0), 32'h20);
        settle();
        rd(ad(3, 0), d); chk("R2 active-low idle", d, 32'h20);
        wr(ad(3, 0), 32'h20);
        rd(ad(3, 0), d); chk("R4 w1c on level", d, 32'h20);
        @(negedge clk); ev_in[5] = 1'b1;
        settle();
        rd(ad(3, 0), d); chk("R2 active-low driven", d, 0);
    endtask

    task automatic t_rise();
        logic [31:0] d;
        do_reset();
        wr(ad(0, 1), 32'h100);
        settle();
        rd(ad(3, 1), d); chk("R3 edge idle", d, 0);
        @(negedge clk); ev_in[40] = 1'b1;
        repeat (2) @(negedge clk); ev_in[40] = 1'b0;
        settle();
        rd(ad(3, 1), d); chk("R3 rising sticky", d, 32'h100);
        wr(ad(3, 1), 32'h0);
        rd(ad(3, 1), d); chk("R4 zero write kept", d, 32'h100);
        wr(ad(3, 1), 32'h100);
        rd(ad(3, 1), d); chk("R4 w1c clears", d, 0);
    endtask

    task automatic t_fall();
        logic [31:0] d;
        do_reset();
        wr(ad(0, 3), 32'h4);
        wr(ad(1, 3), 32'h4);
        wr(ad(2, 3), 32'h4);
        wr(ad(9, 3), 32'h4);
        @(negedge clk); ev_in[98] = 1'b1;
        settle();
        rd(ad(3, 3), d); chk("R3 rise ignored in falling mode", d, 0);
        chk("R7 wake idle", {31'd0, wake_out}, 0);
        @(negedge clk); ev_in[98] = 1'b0;
        settle();
        rd(ad(3, 3), d); chk("R3 falling sticky", d, 32'h4);
        chk("R7 wake", {27'd0, wake_out, irq_out}, 32'h10);
        rd(ad(15, 0), d); chk("R7 out reg wake", d, 32'h10);
        rd(ad(14, 3), d); chk("R6 opnd4 g3", d, 32'h4);
        rd(ad(10, 3), d); chk("R6 opnd0 g3", d, 0);
    endtask

    task automatic t_map();
        logic [31:0] d;
        do_reset();
        wr(ad(2, 3), 32'hFFFF_FFFF);
        rd(ad(2, 3), d); chk("R8 gen g3 pad", d, 32'h7);
        wr(ad(6, 3), 32'hFFFF_FFF8);
        rd(ad(6, 3), d); chk("R8 oen1 g3 pad", d, 0);
        wr(ad(0, 0), 32'hA5A5_A5A5);
        wr(ad(1, 0), 32'h0);
        rd(ad(0, 0), d); chk("R9 mode readback", d, 32'hA5A5_A5A5);
        wr(ad(8, 1), 32'h1234_5678);
        rd(ad(8, 1), d); chk("R9 oen3 readback", d, 32'h1234_5678);
        rd(ad(16, 0), d); chk("R10 unmapped", d, 0);
        rd(ad(15, 1), d); chk("R10 out reg g1", d, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_level();
        t_polarity();
        t_rise();
        t_fall();
        t_map();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule